// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

The block gathers interrupt requests from a parameterized set of sources, up to 112. Each source owns a small control register. The register holds a pending flag, an enable bit, a 4-bit priority level and a 3-bit group level. The group level is formed from a 2-bit field plus a separate high-order extension bit. Every cycle the block scans all enabled, pending sources and selects one winner. It then checks the winner against the CPU's current priority and the global interrupt enable. When the CPU may take the winner, the block raises an interrupt request and presents a trap number for that source.

A separate wake output tells an idle CPU that work is waiting. It is driven by any enabled pending source. It does not depend on the global enable, on the CPU level or on the source's own level. Level-0 requests therefore wake the CPU but are never taken, since level 0 is the CPU's resting level. Software reaches each control register through a single indexed read/write port. Hardware sets a source's flag through a per-source pulse. The flag is cleared when the CPU acknowledges that source.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset every control register reads 0x0000, and irq_req and wake are low.
- R2: Control register layout: bit 8 is the group extension, bit 7 the pending flag (1 = pending), bit 6 the enable (1 = enabled), bits 5:2 the priority level and bits 1:0 the low group field. A write stores bits 8:0 and reads back unchanged. Bits 15:9 always read zero, and writing ones to them has no effect.
- R3: wake is high whenever at least one source has both its flag and its enable set. This holds with the global enable low and for level-0 sources.
- R4: While glb_en is low, irq_req stays low whatever the sources hold.
- R5: A winner whose level is lower than or equal to cpu_lvl is not taken: irq_req stays low and its flag stays set.
- R6: A winner with level 0 is never taken, even with cpu_lvl at 0.
- R7: The winner is chosen by higher level first, then by higher 3-bit group {bit 8, bits 1:0}, then by lower source index.
- R8: While irq_req is high, irq_trap equals 0x10 plus the winner's source index.
- R9: cpu_ack high in a cycle with irq_req high clears the winner's flag at the next clock edge.
- R10: A src_set pulse for a source forces its flag to 1 at the next edge. This overrides a software write or an acknowledge to that source in the same cycle.
- R11: A source with its enable clear neither competes nor drives wake, even with its flag set.
- R12: A reg_sel value at or beyond the source count reads 0x0000, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_set | input | N_SRC | Per-source request pulse that sets the flag |
| reg_sel | input | 7 | Index of the control register being accessed |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| glb_en | input | 1 | Global interrupt enable |
| cpu_lvl | input | 4 | Current CPU priority level |
| cpu_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_trap | output | 8 | Trap number of the presented request |
| wake | output | 1 | Wake-from-idle indication |

## Verification
The bench builds the block with N_SRC = 6. This small count allows register index 6 to exercise the out-of-range select path. It also keeps every source available for deliberate ties on level and on group. With six sources the tests can set up each tie-break layer on its own: level, group extension bit, low group field and index. The same count reaches the same-cycle conflicts between a request pulse, a software write and an acknowledge on one flag.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int MAX_SRC   = 112;
    localparam int SEL_W     = 7;
    localparam int TRAP_W    = 8;
    localparam int TRAP_BASE = 16;

    // Field order matches register bits 8..0.
    typedef struct packed {
        logic       gx;     // group extension (bit 8)
        logic       pend;   // pending flag    (bit 7)
        logic       ena;    // enable          (bit 6)
        logic [3:0] lvl;    // priority level  (bits 5:2)
        logic [1:0] grp;    // low group field (bits 1:0)
    } irq_ctl_t;

    localparam int CTL_W = $bits(irq_ctl_t);

    // Ranking key: level above group extension above low group.
    function automatic logic [6:0] rank_key(irq_ctl_t c);
        return {c.lvl, c.gx, c.grp};
    endfunction

endpackage

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  irq_ctl_t wr_val,
    input  logic     hw_set,
    input  logic     ack_clr,
    output irq_ctl_t ctl_q
);

    irq_ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wr_val;
        end else if (ack_clr) begin
            ctl_d.pend = 1'b0;
        end
        if (hw_set) begin
            ctl_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R10: a hardware request always lands
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> ctl_q.pend);

    // R9: acknowledge alone clears the flag
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !hw_set && !wr_en) |=> !ctl_q.pend);

endmodule

// File: rtl/irq_win_sel.sv
module irq_win_sel
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  irq_ctl_t [N_SRC-1:0]  ctl,
    output logic                  win_vld,
    output logic [IDX_W-1:0]      win_idx,
    output logic [3:0]            win_lvl
);

    logic [6:0] best_key;

    always_comb begin
        win_vld  = 1'b0;
        win_idx  = '0;
        best_key = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (ctl[i].ena && ctl[i].pend) begin
                // strict compare keeps the lowest index on a full tie
                if (!win_vld || rank_key(ctl[i]) > best_key) begin
                    win_vld  = 1'b1;
                    win_idx  = IDX_W'(i);
                    best_key = rank_key(ctl[i]);
                end
            end
        end
        win_lvl = best_key[6:3];
    end

    // R7: the chosen source is live, R11: disabled sources never win
    a_r7_pick_live: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (ctl[win_idx].ena && ctl[win_idx].pend));

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_set,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic               reg_wr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    input  logic               glb_en,
    input  logic [3:0]         cpu_lvl,
    input  logic               cpu_ack,
    output logic               irq_req,
    output logic [TRAP_W-1:0]  irq_trap,
    output logic               wake
);

    irq_ctl_t [N_SRC-1:0] ctl_q;
    logic                 win_vld;
    logic [IDX_W-1:0]     win_idx;
    logic [3:0]           win_lvl;
    logic [N_SRC-1:0]     live;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic wr_hit;
        logic ack_hit;
        assign wr_hit  = reg_wr && (reg_sel == SEL_W'(i));
        assign ack_hit = irq_req && cpu_ack && (win_idx == IDX_W'(i));
        assign live[i] = ctl_q[i].ena && ctl_q[i].pend;

        irq_ctl_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit),
            .wr_val  (irq_ctl_t'(reg_wdata[CTL_W-1:0])),
            .hw_set  (src_set[i]),
            .ack_clr (ack_hit),
            .ctl_q   (ctl_q[i])
        );
    end

    irq_win_sel #(.N_SRC(N_SRC)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl_q),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (reg_sel == SEL_W'(i)) reg_rdata = {{(16-CTL_W){1'b0}}, ctl_q[i]};
        end
    end

    assign wake     = |live;
    assign irq_req  = win_vld && glb_en && (win_lvl > cpu_lvl);
    assign irq_trap = TRAP_W'(TRAP_BASE) + TRAP_W'(win_idx);

    // R3: anything taken must also wake the CPU
    a_r3_req_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake);

    // R8: trap number lies above the reserved range and inside the source set
    a_r8_trap_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_trap >= TRAP_W'(TRAP_BASE)) && (irq_trap < TRAP_W'(TRAP_BASE + N_SRC)));

    // R6: a level-0 source is never reported as taken
    a_r6_no_level0: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (ctl_q[win_idx].lvl != 4'd0));

    // R2: reserved read bits stay zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[15:CTL_W] == '0);

endmodule

// File: tb/sim_irq_prio_arb.sv
module sim_irq_prio_arb;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_set = '0;
    logic [6:0]   reg_sel = '0;
    logic         reg_wr = 1'b0;
    logic [15:0]  reg_wdata = '0;
    logic [15:0]  reg_rdata;
    logic         glb_en = 1'b0;
    logic [3:0]   cpu_lvl = '0;
    logic         cpu_ack = 1'b0;
    logic         irq_req;
    logic [7:0]   irq_trap;
    logic         wake;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_arb #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glb_en(glb_en), .cpu_lvl(cpu_lvl), .cpu_ack(cpu_ack),
        .irq_req(irq_req), .irq_trap(irq_trap), .wake(wake)
    );

    function automatic logic [15:0] mk(bit gx, bit pend, bit ena, int lvl, int grp);
        return {7'b0, gx, pend, ena, 4'(lvl), 2'(grp)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int s, logic [15:0] d);
        @(negedge clk);
        reg_sel = 7'(s); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, int s, logic [15:0] exp);
        reg_sel = 7'(s);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) wr(i, 16'h0000);
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) rd_chk("R1 reg reset", i, 16'h0000);
        chk("R1 irq_req reset", irq_req, 0);
        chk("R1 wake reset", wake, 0);
    endtask

    task automatic t_layout();
        wr(0, 16'hFFFF);
        rd_chk("R2 full write", 0, 16'h01FF);
        wr(0, 16'hFE00);
        rd_chk("R2 upper bits ignored", 0, 16'h0000);
        wr(0, mk(1, 0, 1, 5, 1));
        rd_chk("R2 field layout", 0, 16'h0155);
        wr(0, 16'h0000);
    endtask

    task automatic t_range();
        wr(6, 16'hFFFF);
        rd_chk("R12 out of range read", 6, 16'h0000);
        for (int i = 0; i < N; i++) rd_chk("R12 no side effect", i, 16'h0000);
    endtask

    task automatic t_wake();
        glb_en = 1'b0;
        wr(2, mk(0, 0, 1, 0, 0));
        @(negedge clk); src_set = 6'b000100;
        @(negedge clk); src_set = '0;
        #1;
        chk("R3 wake with glb_en low, level 0", wake, 1);
        chk("R4 no request with glb_en low", irq_req, 0);
        wr(2, mk(0, 1, 1, 9, 0));
        cpu_lvl = 0; #1;
        chk("R4 high level still blocked", irq_req, 0);
        chk("R3 wake level 9", wake, 1);
        wr(2, mk(0, 1, 0, 9, 0));
        #1;
        chk("R11 disabled source no wake", wake, 0);
        glb_en = 1'b1; #1;
        chk("R11 disabled source no request", irq_req, 0);
        clear_all();
    endtask

    task automatic t_level0();
        glb_en = 1'b1; cpu_lvl = 0;
        wr(1, mk(1, 1, 1, 0, 3));
        #1;
        chk("R6 level 0 not taken", irq_req, 0);
        chk("R3 level 0 wakes", wake, 1);
        clear_all();
    endtask

    task automatic t_prio();
        glb_en = 1'b1; cpu_lvl = 0;
        wr(1, mk(0, 1, 1, 3, 2));
        wr(3, mk(0, 1, 1, 5, 0));
        wr(4, mk(0, 1, 1, 5, 1));
        wr(5, mk(1, 1, 1, 5, 0));
        #1;
        chk("R7 group extension wins", irq_req, 1);
        chk("R8 trap of source 5", irq_trap, 8'h15);
        wr(5, 16'h0000); #1;
        chk("R7 low group decides", irq_trap, 8'h14);
        wr(3, mk(0, 1, 1, 5, 1)); #1;
        chk("R7 lower index on tie", irq_trap, 8'h13);
        cpu_lvl = 5; #1;
        chk("R5 equal level not taken", irq_req, 0);
        rd_chk("R5 flag stays pending", 3, mk(0, 1, 1, 5, 1));
        cpu_lvl = 4; #1;
        chk("R5 higher level taken", irq_req, 1);
    endtask

    task automatic t_ack();
        // winner is 3 (trap 0x13) from previous scenario
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
        rd_chk("R9 ack clears flag", 3, mk(0, 0, 1, 5, 1));
        chk("R9 next winner after ack", irq_trap, 8'h14);
        // ack and request pulse on the same winner
        @(negedge clk); cpu_ack = 1'b1; src_set = 6'b010000;
        @(negedge clk); cpu_ack = 1'b0; src_set = '0;
        rd_chk("R10 set beats ack", 4, mk(0, 1, 1, 5, 1));
        // write with flag 0 plus request pulse in the same cycle
        @(negedge clk);
        reg_sel = 7'd1; reg_wdata = mk(0, 0, 1, 2, 0); reg_wr = 1'b1; src_set = 6'b000010;
        @(negedge clk);
        reg_wr = 1'b0; src_set = '0;
        rd_chk("R10 set beats write", 1, mk(0, 1, 1, 2, 0));
        clear_all();
        #1;
        chk("R3 wake drops when clear", wake, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_range();
        t_wake();
        t_level0();
        t_prio();
        t_ack();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule